// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Feedback Divider

This block divides a fast clock by a programmable integer N. It is meant for the feedback path of a frequency synthesizer. Inside it, a dual-ratio prescaler counts fast-clock cycles in periods of either Nlow or Nlow+1. Two down-counters advance once per prescaler period. The period counter sets how many prescaler periods make up one divider cycle. The swallow counter sets how many of those periods use the longer ratio. Together they give N = P·Nlow + S. The band select picks the ratio pair: 32/33 for the low band and 47/48 for the high band.

The whole block runs in one clock domain, the fast clock. The prescaler's end-of-period strobe acts as a clock enable for both counters, so there are no derived clocks. The period word, swallow word and band select are sampled only when both counters reload at the end of a divider cycle. A one-cycle pulse on the output marks the start of each new divider cycle. The modulus-control line is also brought out, so that the wide and narrow prescaler periods can be seen at the ports.

Top module: `psd_divider`

## Requirements
- R1: The spacing between consecutive `div_out` pulses is exactly Peff·Nlow + Seff fast-clock cycles. Nlow is 32 when the captured `band_sel` is 0 (low band) and 47 when it is 1 (high band).
- R2: The effective period count Peff is `p_word` with bit 3 and bit 6 (zero-based) forced to 1, that is Peff = `p_word` | 72. Any 7-bit `p_word` therefore gives Peff ≥ 72.
- R3: In the low band Seff is `s_word[4:0]`, so bit 5 is ignored. In the high band Seff is `s_word` limited to at most 47.
- R4: `mod_ctl` is 0 (longer ratio, Nlow+1) during the first Seff prescaler periods of each divider cycle and 1 for the rest. The number of fast-clock cycles with `mod_ctl` = 0 in one divider cycle is therefore Seff·(Nlow+1).
- R5: When Seff = 0, `mod_ctl` stays 1 for the entire divider cycle.
- R6: `div_out` is high for exactly one fast-clock cycle per divider cycle. That cycle is the first cycle of the new divider cycle.
- R7: `p_word`, `s_word` and `band_sel` are captured only at the reload that ends a divider cycle. A change in the middle of a cycle does not alter that cycle's length.
- R8: While `rst` is high, `div_out` is 0 and `mod_ctl` is 1. After `rst` falls, the first `div_out` pulse comes 32 cycles later, from one low-band narrow period with no captured setting yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| p_word | input | 7 | Period count before bit forcing |
| s_word | input | 6 | Swallow count before band limiting |
| band_sel | input | 1 | 0 selects ratios 32/33, 1 selects 47/48 |
| div_out | output | 1 | One-cycle pulse per divider cycle |
| mod_ctl | output | 1 | Prescaler modulus control, 0 = longer ratio |

## Verification
The hardest case to reach is a change of the inputs in the middle of a cycle. The old setting must still decide the current cycle's length, and the new one takes effect only at the next reload. The stimulus finds a pulse, lets one full cycle run under a known setting, and then rewrites all three inputs about a thousand cycles into the next cycle. It then measures that cycle against the old setting and the following cycle against the new one. The corner values are reached by choosing raw words whose forced bits or band limits change the effective counts: a `p_word` of 3, an `s_word` above 47, and an `s_word` of 32 in the low band.

// File: rtl/psd_pkg.sv
package psd_pkg;

    parameter int P_W      = 7;
    parameter int S_W      = 6;
    parameter int PRE_W    = 6;
    parameter int NLOW_LO  = 32;
    parameter int NLOW_HI  = 47;
    parameter int S_MAX_HI = 47;
    parameter logic [P_W-1:0] P_FORCE = 7'b1001000;

    typedef enum logic {
        MOD_WIDE   = 1'b0,
        MOD_NARROW = 1'b1
    } mod_e;

    typedef struct packed {
        logic           hi;
        logic [P_W-1:0] p;
        logic [S_W-1:0] s;
    } div_cfg_t;

    // Terminal value of the prescaler's up-count for the chosen ratio.
    function automatic logic [PRE_W-1:0] period_last(input logic hi, input mod_e m);
        int nlow;
        int n;
        nlow = hi ? NLOW_HI : NLOW_LO;
        n    = (m == MOD_WIDE) ? nlow + 1 : nlow;
        return PRE_W'(n - 1);
    endfunction

    // Apply the forced period bits and the band-dependent swallow range.
    function automatic div_cfg_t sanitize(input logic [P_W-1:0] p_raw,
                                          input logic [S_W-1:0] s_raw,
                                          input logic           hi);
        div_cfg_t c;
        c.hi = hi;
        c.p  = p_raw | P_FORCE;
        if (hi) begin
            c.s = (int'(s_raw) > S_MAX_HI) ? S_W'(S_MAX_HI) : s_raw;
        end else begin
            c.s = {1'b0, s_raw[S_W-2:0]};
        end
        return c;
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hi,
    input  mod_e mod,
    output logic tick
);

    logic [PRE_W-1:0] cnt;

    assign tick = (cnt == period_last(hi, mod));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/psd_down_ctr.sv
module psd_down_ctr #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         zero
);

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step && !zero) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] p_word,
    input  logic [S_W-1:0] s_word,
    input  logic           band_sel,
    output logic           div_out,
    output logic           mod_ctl
);

    div_cfg_t       cfg_in;
    logic           band_q;
    logic           tick;
    logic           reload;
    logic [P_W-1:0] p_cnt;
    logic [S_W-1:0] s_cnt;
    logic           p_zero;
    logic           s_zero;
    mod_e           mod;
    logic           div_q;

    assign cfg_in = sanitize(p_word, s_word, band_sel);
    assign mod    = s_zero ? MOD_NARROW : MOD_WIDE;
    assign reload = tick && p_zero;

    psd_prescaler i_pre (
        .clk  (clk),
        .rst  (rst),
        .hi   (band_q),
        .mod  (mod),
        .tick (tick)
    );

    // Period counter: holds the number of prescaler periods left after this one.
    psd_down_ctr #(.W(P_W)) i_pctr (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (cfg_in.p - 1'b1),
        .step     (tick),
        .cnt      (p_cnt),
        .zero     (p_zero)
    );

    // Swallow counter: holds the number of wide periods still to come.
    psd_down_ctr #(.W(S_W)) i_sctr (
        .clk      (clk),
        .rst      (rst),
        .load     (reload),
        .load_val (cfg_in.s),
        .step     (tick),
        .cnt      (s_cnt),
        .zero     (s_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= 1'b0;
            div_q  <= 1'b0;
        end else begin
            div_q <= reload;
            if (reload) begin
                band_q <= cfg_in.hi;
            end
        end
    end

    assign div_out = div_q;
    assign mod_ctl = (mod == MOD_NARROW);

endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk
    import psd_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           div_out,
    input logic           mod_ctl,
    input logic           tick,
    input logic           band_q,
    input logic [P_W-1:0] p_cnt,
    input logic [S_W-1:0] s_cnt
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);                                   // R6

    AST_WIDE_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_ctl) |-> div_out);                             // R4

    AST_BAND_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_q) |-> div_out);                           // R7

    AST_LOW_SWALLOW_RANGE: assert property (@(posedge clk) disable iff (rst)
        !band_q |-> (s_cnt < S_W'(32)));                         // R3

    AST_HIGH_SWALLOW_RANGE: assert property (@(posedge clk) disable iff (rst)
        band_q |-> (s_cnt <= S_W'(S_MAX_HI)));                   // R3

    AST_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(p_cnt));                               // R1

    AST_NARROW_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (s_cnt == '0) |-> mod_ctl);                              // R5

endmodule

bind psd_divider psd_divider_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .div_out (div_out),
    .mod_ctl (mod_ctl),
    .tick    (tick),
    .band_q  (band_q),
    .p_cnt   (p_cnt),
    .s_cnt   (s_cnt)
);

// File: tb/test_psd_divider.sv
module test_psd_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] p_word = '0;
    logic [5:0] s_word = '0;
    logic       band_sel = 1'b0;
    logic       div_out;
    logic       mod_ctl;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  timeout  = 0;
    bit  done     = 0;

    always #2.5 clk = ~clk;

    psd_divider i_psd_divider (
        .clk      (clk),
        .rst      (rst),
        .p_word   (p_word),
        .s_word   (s_word),
        .band_sel (band_sel),
        .div_out  (div_out),
        .mod_ctl  (mod_ctl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int peff(input int p);
        return p | 72;
    endfunction

    function automatic int seff(input int s, input bit hi);
        if (hi) return (s > 47) ? 47 : s;
        return s % 32;
    endfunction

    function automatic int nlow(input bit hi);
        return hi ? 47 : 32;
    endfunction

    // Entered at a negedge where div_out is high; returns at the next one.
    task automatic run_cycle(output int n, output int lw, output bit wide);
        n = 0; lw = 0; wide = 0;
        do begin
            if (!mod_ctl) lw++;
            n++;
            @(negedge clk);
            if (n == 1 && div_out) wide = 1;
        end while (!div_out && !timeout);
    endtask

    task automatic measure(input int p, input int s, input bit hi);
        int n, lw, e_n, e_lw;
        bit wide;
        p_word = 7'(p); s_word = 6'(s); band_sel = hi;
        run_cycle(n, lw, wide);
        run_cycle(n, lw, wide);
        e_n  = peff(p) * nlow(hi) + seff(s, hi);
        e_lw = seff(s, hi) * (nlow(hi) + 1);
        chk($sformatf("R1/R2/R3 period p=%0d s=%0d hi=%0d", p, s, hi), n, e_n);
        if (seff(s, hi) == 0)
            chk($sformatf("R5 no wide period p=%0d hi=%0d", p, hi), lw, 0);
        else
            chk($sformatf("R4 wide cycles p=%0d s=%0d hi=%0d", p, s, hi), lw, e_lw);
        chk("R6 pulse width", int'(wide), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            timeout = 1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int k, n, lw;
        bit wide;
        repeat (3) @(negedge clk);
        chk("R8 div_out in reset", int'(div_out), 0);
        chk("R8 mod_ctl in reset", int'(mod_ctl), 1);
        p_word = 7'd75; s_word = 6'd0; band_sel = 1'b0;
        rst = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!div_out && !timeout);
        chk("R8 first pulse delay", k, 32);

        // Low band sweep, including forced bits and masked swallow bit
        measure(75, 0, 0);
        measure(76, 1, 0);
        measure(77, 17, 0);
        measure(78, 31, 0);
        measure(3, 40, 0);      // R2: Peff 75, R3: Seff 8
        measure(0, 32, 0);      // R2: Peff 72, R3: Seff 0

        // High band sweep, including limiting of the swallow count
        measure(105, 0, 1);
        measure(122, 47, 1);
        measure(113, 20, 1);
        measure(105, 60, 1);    // R3: Seff 47
        measure(41, 5, 1);      // R2: Peff 105

        // R7: mid-cycle change must not affect the running cycle
        measure(76, 9, 0);
        fork
            begin
                repeat (1000) @(negedge clk);
                p_word = 7'd110; s_word = 6'd30; band_sel = 1'b1;
            end
        join_none
        run_cycle(n, lw, wide);
        chk("R7 running cycle keeps old setting", n, 76 * 32 + 9);
        run_cycle(n, lw, wide);
        chk("R7 next cycle takes new setting", n, 110 * 47 + 30);
        chk("R7 new wide cycles", lw, 30 * 48);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule